// File: doc/BRIEF.md
# PLL Lock Retry Sequencer

This block brings a PLL-derived system clock up safely after power-on or after waking from a deep low-power state. It runs entirely from the reference clock. It drives the PLL enable and the system-clock source select, and it reads the PLL lock indication and the slip indication. The lock indication can be high while the PLL produces no clock. For that reason, on a full bring-up the block repeats a complete lock sequence a fixed number of times before it hands the system clock to the PLL. One lock sequence is: hold the enable low for one cycle, raise it, then wait for lock.

Before the source select moves to the PLL, the block arms an external watchdog that also counts reference clocks. If the PLL clock turns out to be dead, that watchdog resets the device. A sticky retry flag is set whenever a bring-up begins. A device reset leaves this flag alone, so software can tell a bring-up watchdog reset from other watchdog resets. In the first cycle after the switch, the slip input is sampled. A reported slip returns the source to the reference clock and runs a single re-lock, and this repeats until a switch is slip-free.

Once a bring-up has succeeded, later start requests run only one lock sequence. The full procedure is needed again after the next power-on reset or wake indication. Every wait for lock is bounded by a timeout. When it expires, the sequence restarts and the attempt is not counted.

Top module: `pll_lock_sequencer`

## Requirements
- R1: While `rst` or `por` is high, and in the cycle after, `pll_en`, `clk_sel`, `wd_en` and `done` are 0.
- R2: After power-on, a start request causes exactly NUM_SEQ (default 5) rising edges of `pll_en` before `clk_sel` first rises. Before each rise, `pll_en` is low for at least one cycle, and each wait ends on `lock`.
- R3: `wd_en` is 1 in the cycle before any cycle in which `clk_sel` rises.
- R4: `retry_flag` is set on every accepted start. It is unaffected by `rst` and is cleared only by `retry_flag_clr` or `por`. When a set and a clear fall in the same cycle, the set wins.
- R5: When `slip` is high during the first cycle of `clk_sel`=1, then in the next cycle `clk_sel` and `pll_en` are 0. After that, one lock sequence runs and the switch is tried again, and this repeats until a switch sees no slip.
- R6: `done` is 1 for every cycle spent running after a slip-free switch, and it implies that `clk_sel`, `pll_en` and `wd_en` are all 1.
- R7: After a successful bring-up, a start request, with or without an intervening `rst`, runs a single lock sequence. After `por` or a `wake` pulse, the next start again runs NUM_SEQ sequences.
- R8: If `lock` does not arrive within LOCK_TIMEOUT cycles of `pll_en` rising, `pll_en` falls after exactly LOCK_TIMEOUT cycles high, and the attempt is not counted toward NUM_SEQ.
- R9: A start request is accepted only while idle or running. A start during a bring-up has no effect on the number of lock sequences.
- R10: `wd_en` rises one cycle before the first switch and stays high through slip re-locks and running. An accepted start clears it in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous device reset, active high (keeps the retry flag) |
| por | input | 1 | Synchronous power-on reset, active high (clears everything) |
| start | input | 1 | Request to run a bring-up |
| wake | input | 1 | Pulse on wake from the low-power state; forces a full bring-up next |
| lock | input | 1 | PLL lock indication |
| slip | input | 1 | PLL slip indication |
| retry_flag_clr | input | 1 | Software clear strobe for the retry flag |
| pll_en | output | 1 | PLL enable |
| clk_sel | output | 1 | System-clock source select, 1 selects the PLL |
| wd_en | output | 1 | Arms the reference-clocked watchdog in reset-request mode |
| retry_flag | output | 1 | Sticky bring-up-in-progress flag |
| done | output | 1 | Running on the PLL clock after a slip-free switch |

## Verification
The assertions assume that `slip` is only meaningful while `clk_sel` is high and that `lock` falls once `pll_en` has been low for a cycle. They also assume `start` and `retry_flag_clr` are single-cycle pulses that change away from the clock edge. The bench builds the lock input from a responder that follows `pll_en` with a fixed delay, and it can hold lock off to force a timeout. It raises `slip` only during the switch cycle, against a budget set by each scenario, so every stimulus stays inside these assumptions.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OFF,
    ST_WAIT,
    ST_ARM,
    ST_SWITCH,
    ST_RUN
  } seq_state_t;
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr || !run) begin
      cnt <= '0;
    end else if (!expired) begin
      cnt <= cnt + W'(1);
    end
  end

  assign expired = run && (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/pll_seq_attempts.sv
module pll_seq_attempts #(
  parameter int MAX = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_full,
  input  logic hit,
  output logic last
);
  localparam int W = $clog2(MAX + 1);

  logic [W-1:0] cnt;
  logic [W-1:0] target;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      target <= W'(MAX);
    end else if (load) begin
      cnt    <= '0;
      target <= load_full ? W'(MAX) : W'(1);
    end else if (hit) begin
      cnt <= cnt + W'(1);
    end
  end

  assign last = (cnt == target - W'(1));
endmodule

// File: rtl/pll_seq_flags.sv
module pll_seq_flags (
  input  logic clk,
  input  logic por,
  input  logic wake,
  input  logic set_retry,
  input  logic clr_retry,
  input  logic success,
  output logic retry_flag,
  output logic full_needed
);
  always_ff @(posedge clk) begin
    if (por) begin
      retry_flag  <= 1'b0;
      full_needed <= 1'b1;
    end else begin
      if (set_retry) begin
        retry_flag <= 1'b1;
      end else if (clr_retry) begin
        retry_flag <= 1'b0;
      end
      if (wake) begin
        full_needed <= 1'b1;
      end else if (success) begin
        full_needed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pll_lock_sequencer.sv
module pll_lock_sequencer
  import pll_seq_pkg::*;
#(
  parameter int NUM_SEQ      = 5,
  parameter int LOCK_TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic por,
  input  logic start,
  input  logic wake,
  input  logic lock,
  input  logic slip,
  input  logic retry_flag_clr,
  output logic pll_en,
  output logic clk_sel,
  output logic wd_en,
  output logic retry_flag,
  output logic done
);
  seq_state_t state, state_n;
  logic rst_all;
  logic accept;
  logic lock_hit;
  logic slip_hit;
  logic success;
  logic last;
  logic expired;
  logic full_needed;

  assign rst_all  = rst || por;
  assign accept   = start && ((state == ST_IDLE) || (state == ST_RUN));
  assign lock_hit = (state == ST_WAIT) && lock;
  assign slip_hit = (state == ST_SWITCH) && slip;
  assign success  = (state == ST_SWITCH) && !slip;

  pll_seq_timer #(.LIMIT(LOCK_TIMEOUT)) i_timer (
    .clk     (clk),
    .clr     (rst_all),
    .run     (state == ST_WAIT),
    .expired (expired)
  );

  pll_seq_attempts #(.MAX(NUM_SEQ)) i_attempts (
    .clk       (clk),
    .rst       (rst_all),
    .load      (accept || slip_hit),
    .load_full (accept && full_needed),
    .hit       (lock_hit),
    .last      (last)
  );

  pll_seq_flags i_flags (
    .clk         (clk),
    .por         (por),
    .wake        (wake),
    .set_retry   (accept),
    .clr_retry   (retry_flag_clr),
    .success     (success),
    .retry_flag  (retry_flag),
    .full_needed (full_needed)
  );

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:   if (accept) state_n = ST_OFF;
      ST_OFF:    state_n = ST_WAIT;
      ST_WAIT: begin
        if (lock)         state_n = last ? ST_ARM : ST_OFF;
        else if (expired) state_n = ST_OFF;
      end
      ST_ARM:    state_n = ST_SWITCH;
      ST_SWITCH: state_n = slip ? ST_OFF : ST_RUN;
      ST_RUN:    if (accept) state_n = ST_OFF;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_all) begin
      state   <= ST_IDLE;
      pll_en  <= 1'b0;
      clk_sel <= 1'b0;
      wd_en   <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= state_n;
      pll_en  <= (state_n == ST_WAIT) || (state_n == ST_ARM) ||
                 (state_n == ST_SWITCH) || (state_n == ST_RUN);
      clk_sel <= (state_n == ST_SWITCH) || (state_n == ST_RUN);
      done    <= (state_n == ST_RUN);
      if (accept) begin
        wd_en <= 1'b0;
      end else if (state_n == ST_ARM) begin
        wd_en <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_seq_checker.sv
module pll_seq_checker (
  input logic clk,
  input logic rst,
  input logic por,
  input logic start,
  input logic slip,
  input logic retry_flag_clr,
  input logic pll_en,
  input logic clk_sel,
  input logic wd_en,
  input logic retry_flag,
  input logic done
);
  logic seen = 1'b0;

  always_ff @(posedge clk) seen <= 1'b1;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    (seen && (rst || por)) |=> (!pll_en && !clk_sel && !wd_en && !done));

  assert_wd_before_switch_R3: assert property (@(posedge clk) disable iff (rst || por)
    $rose(clk_sel) |-> $past(wd_en));

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (por)
    (seen && retry_flag && !retry_flag_clr) |=> retry_flag);

  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (por)
    (seen && retry_flag_clr && !start) |=> !retry_flag);

  assert_slip_backs_off_R5: assert property (@(posedge clk) disable iff (rst || por)
    (clk_sel && !done && slip) |=> (!clk_sel && !pll_en));

  assert_running_outputs_R6: assert property (@(posedge clk) disable iff (rst || por)
    done |-> (clk_sel && pll_en && wd_en));

  assert_sel_needs_pll_R6: assert property (@(posedge clk) disable iff (rst || por)
    clk_sel |-> pll_en);
endmodule

bind pll_lock_sequencer pll_seq_checker i_pll_seq_checker (
  .clk            (clk),
  .rst            (rst),
  .por            (por),
  .start          (start),
  .slip           (slip),
  .retry_flag_clr (retry_flag_clr),
  .pll_en         (pll_en),
  .clk_sel        (clk_sel),
  .wd_en          (wd_en),
  .retry_flag     (retry_flag),
  .done           (done)
);

// File: tb/test_pll_lock_sequencer.sv
module test_pll_lock_sequencer;
  localparam int CLK_PERIOD   = 10;
  localparam int NUM_SEQ      = 5;
  localparam int LOCK_TIMEOUT = 64;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic por = 1'b1;
  logic start = 1'b0;
  logic wake = 1'b0;
  logic lock = 1'b0;
  logic slip;
  logic retry_flag_clr = 1'b0;
  logic pll_en, clk_sel, wd_en, retry_flag, done;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  bit lock_ok = 1'b1;
  int lcnt = 0;
  int slip_budget = 0;
  int slip_seen = 0;

  int en_rises = 0;
  int sel_rises = 0;
  int sel_snap = 0;
  int wd_falls = 0;
  bit wd_before_sel = 1'b0;
  logic en_q = 1'b0, sel_q = 1'b0, wd_q = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pll_lock_sequencer #(.NUM_SEQ(NUM_SEQ), .LOCK_TIMEOUT(LOCK_TIMEOUT)) i_pll_lock_sequencer (
    .clk            (clk),
    .rst            (rst),
    .por            (por),
    .start          (start),
    .wake           (wake),
    .lock           (lock),
    .slip           (slip),
    .retry_flag_clr (retry_flag_clr),
    .pll_en         (pll_en),
    .clk_sel        (clk_sel),
    .wd_en          (wd_en),
    .retry_flag     (retry_flag),
    .done           (done)
  );

  always @(posedge clk) begin
    if (!pll_en || !lock_ok) begin
      lock <= 1'b0;
      lcnt <= 0;
    end else if (lcnt >= 3) begin
      lock <= 1'b1;
    end else begin
      lcnt <= lcnt + 1;
    end
  end

  assign slip = clk_sel && !done && (slip_seen < slip_budget);

  always @(posedge clk) if (slip) slip_seen <= slip_seen + 1;

  always @(negedge clk) begin
    if (pll_en === 1'b1 && !en_q) en_rises = en_rises + 1;
    if (clk_sel === 1'b1 && !sel_q) begin
      sel_rises = sel_rises + 1;
      sel_snap = en_rises;
      wd_before_sel = wd_q;
    end
    if (wd_en !== 1'b1 && wd_q) wd_falls = wd_falls + 1;
    en_q  = (pll_en === 1'b1);
    sel_q = (clk_sel === 1'b1);
    wd_q  = (wd_en === 1'b1);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (done !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(req, "done reached", int'(done === 1'b1), 1);
  endtask

  task automatic check_quiet(input string req);
    chk(req, "pll_en", int'(pll_en), 0);
    chk(req, "clk_sel", int'(clk_sel), 0);
    chk(req, "wd_en", int'(wd_en), 0);
    chk(req, "done", int'(done), 0);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check_quiet("R1");
    chk("R4", "flag after por", int'(retry_flag), 0);
    por = 1'b0;
    @(negedge clk);
    check_quiet("R1");
  endtask

  task automatic t_full_bringup();
    int base = en_rises;
    pulse_start();
    chk("R4", "flag set on start", int'(retry_flag), 1);
    repeat (3) @(negedge clk);
    pulse_start();
    wait_done("R2");
    chk("R2", "lock sequences before switch", sel_snap - base, NUM_SEQ);
    chk("R9", "mid-bringup start ignored", sel_snap - base, NUM_SEQ);
    chk("R3", "wd_en before switch", int'(wd_before_sel), 1);
    repeat (10) @(negedge clk);
    chk("R6", "done held", int'(done), 1);
    chk("R6", "clk_sel while running", int'(clk_sel), 1);
    chk("R6", "pll_en while running", int'(pll_en), 1);
  endtask

  task automatic t_single_restart();
    int base = en_rises;
    pulse_start();
    chk("R10", "wd_en cleared by start", int'(wd_en), 0);
    chk("R6", "done cleared by start", int'(done), 0);
    wait_done("R7");
    chk("R7", "single sequence after success", sel_snap - base, 1);
  endtask

  task automatic t_rst_keeps_state();
    int base;
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check_quiet("R1");
    chk("R4", "flag survives rst", int'(retry_flag), 1);
    base = en_rises;
    pulse_start();
    wait_done("R7");
    chk("R7", "single sequence after rst", sel_snap - base, 1);
  endtask

  task automatic t_slip();
    int base = en_rises;
    int sbase = sel_rises;
    int wbase = wd_falls;
    int slbase = slip_seen;
    slip_budget = slip_seen + 2;
    pulse_start();
    wait_done("R5");
    chk("R5", "slips reported", slip_seen - slbase, 2);
    chk("R5", "lock sequences incl re-locks", sel_snap - base, 3);
    chk("R5", "switch attempts", sel_rises - sbase, 3);
    chk("R10", "wd_en falls during re-locks", wd_falls - wbase, 1);
    chk("R10", "wd_en while running", int'(wd_en), 1);
  endtask

  task automatic t_timeout_wake();
    int base;
    int n = 0;
    @(negedge clk) wake = 1'b1;
    @(negedge clk) wake = 1'b0;
    lock_ok = 1'b0;
    base = en_rises;
    pulse_start();
    while (pll_en !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    n = 0;
    while (pll_en === 1'b1 && n < 4 * LOCK_TIMEOUT) begin
      @(negedge clk);
      n++;
    end
    chk("R8", "cycles high before timeout", n, LOCK_TIMEOUT);
    lock_ok = 1'b1;
    wait_done("R8");
    chk("R8", "timeout attempt not counted", sel_snap - base, NUM_SEQ + 1);
    chk("R7", "wake restores full bring-up", sel_snap - base, NUM_SEQ + 1);
  endtask

  task automatic t_flag();
    int base;
    @(negedge clk) retry_flag_clr = 1'b1;
    @(negedge clk) retry_flag_clr = 1'b0;
    chk("R4", "flag cleared by strobe", int'(retry_flag), 0);
    @(negedge clk) begin
      start = 1'b1;
      retry_flag_clr = 1'b1;
    end
    @(negedge clk) begin
      start = 1'b0;
      retry_flag_clr = 1'b0;
    end
    chk("R4", "set wins over clear", int'(retry_flag), 1);
    wait_done("R4");
    @(negedge clk) por = 1'b1;
    @(negedge clk) por = 1'b0;
    chk("R4", "flag cleared by por", int'(retry_flag), 0);
    check_quiet("R1");
    base = en_rises;
    pulse_start();
    wait_done("R7");
    chk("R7", "full bring-up after por", sel_snap - base, NUM_SEQ);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_full_bringup();
    t_single_restart();
    t_rst_keeps_state();
    t_slip();
    t_timeout_wake();
    t_flag();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=hung expected=complete");
      summary();
    end
  end
endmodule